// File: doc/BRIEF.md
# FIFO DMA Request Handshake Controller

This block drives the DMA request line for a byte FIFO in a parallel-port style peripheral. It decides when the FIFO should ask the host DMA controller for service. It turns each host acknowledge cycle into a single-clock FIFO read or write strobe. On terminal count it raises an interrupt pulse and a hardware set of the software service bit. The FIFO is seen only through its empty and full flags. The host controller and the peripheral-side handshake sit outside the block.

In the FIFO-to-host direction the request follows the presence of data. In the host-to-FIFO direction it follows the presence of free space. Two rules can hold the request down while the data condition is met. The first is a burst limit: after 32 acknowledged cycles in a row, the request stays off until the acknowledge has been released for a programmable time. The second is a terminal-count lockout, which needs software to set and then clear the service bit before requests resume. The acknowledge and read strobes are asynchronous. They pass through two-flop synchronisers with edge detection, and the reset is released synchronously inside the block.

Top module: `dmareq_ctrl`

## Requirements
- R1: `dreq` is registered. In the clock after `dma_enable` is 0 or `svc_intr` is 1, `dreq` is 0.
- R2: With `dir_to_host`=1, `dreq` is 1 one clock after `fifo_empty`=0, provided every other condition allows it. It is 0 one clock after `fifo_empty`=1.
- R3: One acknowledged DMA cycle is either a falling edge of synchronised `dack_n`, or, with `dir_to_host`=1 and `dack_n` held low, a falling edge of synchronised `ior_n`. A cycle taken with `tc`=1 removes `dreq` at the next clock edge.
- R4: The 32nd acknowledged cycle in a row removes `dreq` at the next edge. `dreq` then stays 0 until synchronised `dack_n` has been high for HOLD_CLKS = ceil(HOLD_NS/CLK_NS) consecutive clocks (18 at the defaults). If `dack_n` goes low during that window, the window starts again.
- R5: An acknowledged cycle with `tc`=1 gives `svc_set`=1 for that one clock and `irq`=1 for the following clock.
- R6: After `dreq` falls because the FIFO went empty, it returns one clock after `fifo_empty` returns to 0. No software action is needed.
- R7: After a terminal count, `dreq` stays 0 while data is present. Software must drive `svc_intr` to 1 and then to 0. `dreq` returns on the second clock after `svc_intr` returns to 0.
- R8: Every acknowledged cycle produces exactly one single-clock strobe. The strobe is `fifo_rd` when `dir_to_host`=1 and `fifo_wr` when it is 0. It appears in the window after the second rising edge that follows the falling edge of `dack_n`. The strobe does not depend on `dreq`.
- R9: With `dir_to_host`=0, `dreq` is 1 one clock after `fifo_full`=0 and 0 one clock after `fifo_full`=1. The burst-limit and terminal-count rules apply in this direction as well.
- R10: When software sets `svc_intr`=1 and then clears `dma_enable` in the middle of a transfer, `dreq` stays 0. Acknowledged cycles still produce FIFO strobes, so the FIFO can drain or fill.
- R11: While `rst_n` is low and for two clocks after it rises, `dreq`, `irq`, `svc_set`, `fifo_rd` and `fifo_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_full | input | 1 | FIFO has no free slot |
| dir_to_host | input | 1 | 1: FIFO-to-host transfers, 0: host-to-FIFO |
| dma_enable | input | 1 | Software DMA enable bit |
| svc_intr | input | 1 | Software service bit; 1 blocks requests |
| dack_n | input | 1 | Asynchronous active-low DMA acknowledge |
| ior_n | input | 1 | Asynchronous active-low I/O read strobe |
| tc | input | 1 | Terminal count, sampled with an acknowledged cycle |
| dreq | output | 1 | DMA request to the host |
| fifo_rd | output | 1 | One-clock FIFO read strobe |
| fifo_wr | output | 1 | One-clock FIFO write strobe |
| irq | output | 1 | One-clock interrupt pulse after terminal count |
| svc_set | output | 1 | One-clock hardware set of the service bit |

## Verification
The burst limit and the terminal count can fall on the same acknowledged cycle. The bench provokes this by running 31 cycles in a row and then raising `tc` on the 32nd. It then checks that `svc_set` and `irq` fire, and that `dreq` stays low after software has already set and cleared the service bit, because the hold-off window has not yet expired. `dreq` must come back only after both locks have been released. A second overlap is an `ior_n` falling edge that arrives while `dack_n` is still held low. That edge must count as exactly one cycle with one strobe. The reference model judges every clock.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  // Terminal-count lockout progress: wait for software to set, then clear, the service bit
  typedef enum logic [1:0] {
    TCL_IDLE     = 2'd0,
    TCL_WAIT_SET = 2'd1,
    TCL_WAIT_CLR = 2'd2
  } tc_lock_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/dmareq_sync.sv
module dmareq_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_n,
  output logic [WIDTH-1:0] lvl_n,
  output logic [WIDTH-1:0] fall
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [2:0] pipe_q;
      logic [2:0] pipe_d;

      always_comb begin
        pipe_d = {pipe_q[1:0], din_n[g]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q <= 3'b111;
        end else begin
          pipe_q <= pipe_d;
        end
      end

      assign lvl_n[g] = pipe_q[1];
      assign fall[g]  = pipe_q[2] & ~pipe_q[1];
    end
  endgenerate

endmodule

// File: rtl/dmareq_burst.sv
module dmareq_burst #(
  parameter int unsigned BURST_MAX = 32,
  parameter int unsigned HOLD_CLKS = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  input  logic req_q,
  input  logic ack_low,
  output logic limit_hit,
  output logic holdoff
);

  localparam int unsigned CW = $clog2(BURST_MAX + 1);
  localparam int unsigned TW = $clog2(HOLD_CLKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          hold_q, hold_d;

  always_comb begin
    limit_hit = xfer && (cnt_q == CW'(BURST_MAX - 1));
    cnt_d     = cnt_q;
    tmr_d     = tmr_q;
    hold_d    = hold_q;
    if (hold_q) begin
      cnt_d = '0;
      if (ack_low) begin
        tmr_d = '0;
      end else if (tmr_q == TW'(HOLD_CLKS - 1)) begin
        tmr_d  = '0;
        hold_d = 1'b0;
      end else begin
        tmr_d = tmr_q + TW'(1);
      end
    end else if (limit_hit) begin
      cnt_d  = '0;
      tmr_d  = '0;
      hold_d = 1'b1;
    end else if (xfer) begin
      cnt_d = cnt_q + CW'(1);
    end else if (!req_q) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tmr_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tmr_q  <= tmr_d;
      hold_q <= hold_d;
    end
  end

  assign holdoff = hold_q;

endmodule

// File: rtl/dmareq_tclock.sv
module dmareq_tclock
  import dmareq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tc_hit,
  input  logic svc_intr,
  output logic locked
);

  tc_lock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TCL_IDLE:     if (tc_hit)    st_d = TCL_WAIT_SET;
      TCL_WAIT_SET: if (svc_intr)  st_d = TCL_WAIT_CLR;
      TCL_WAIT_CLR: if (!svc_intr) st_d = TCL_IDLE;
      default:                     st_d = TCL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TCL_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign locked = (st_q != TCL_IDLE);

endmodule

// File: rtl/dmareq_ctrl.sv
module dmareq_ctrl
  import dmareq_pkg::*;
#(
  parameter int unsigned BURST_MAX = 32,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned HOLD_NS   = 350
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_empty,
  input  logic fifo_full,
  input  logic dir_to_host,
  input  logic dma_enable,
  input  logic svc_intr,
  input  logic dack_n,
  input  logic ior_n,
  input  logic tc,
  output logic dreq,
  output logic fifo_rd,
  output logic fifo_wr,
  output logic irq,
  output logic svc_set
);

  localparam int unsigned HOLD_CLKS = ceil_div(HOLD_NS, CLK_NS);
  localparam int unsigned SYNC_W    = 2;
  localparam int unsigned IDX_ACK   = 0;
  localparam int unsigned IDX_IOR   = 1;

  // Reset: asserted asynchronously, released after two clocks
  logic rst_s1_q, rst_s2_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign rst_int_n = rst_s2_q;

  // Strobe synchronisation
  logic [SYNC_W-1:0] strb_lvl_n, strb_fall;

  dmareq_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din_n ({ior_n, dack_n}),
    .lvl_n (strb_lvl_n),
    .fall  (strb_fall)
  );

  logic ack_low, ack_edge, ior_edge, xfer, tc_hit;

  assign ack_low  = ~strb_lvl_n[IDX_ACK];
  assign ack_edge = strb_fall[IDX_ACK];
  // Read strobe stands in for the acknowledge edge when the acknowledge is held low
  assign ior_edge = strb_fall[IDX_IOR] & ~strb_lvl_n[IDX_IOR];
  assign xfer     = ack_edge | (dir_to_host & ack_low & ior_edge);
  assign tc_hit   = xfer & tc;

  // Burst limit and hold-off
  logic req_q, req_d, limit_hit, holdoff;

  dmareq_burst #(.BURST_MAX(BURST_MAX), .HOLD_CLKS(HOLD_CLKS)) u_burst (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .xfer      (xfer),
    .req_q     (req_q),
    .ack_low   (ack_low),
    .limit_hit (limit_hit),
    .holdoff   (holdoff)
  );

  // Terminal-count lockout
  logic tc_locked;

  dmareq_tclock u_tclock (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tc_hit   (tc_hit),
    .svc_intr (svc_intr),
    .locked   (tc_locked)
  );

  // Request and interrupt registers
  logic data_ok, irq_q, irq_d;

  always_comb begin
    data_ok = dir_to_host ? ~fifo_empty : ~fifo_full;
    req_d   = dma_enable & ~svc_intr & ~tc_locked & ~holdoff & data_ok
              & ~tc_hit & ~limit_hit;
    irq_d   = tc_hit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      req_q <= req_d;
      irq_q <= irq_d;
    end
  end

  assign dreq    = req_q;
  assign irq     = irq_q;
  assign svc_set = tc_hit;
  assign fifo_rd = xfer & dir_to_host;
  assign fifo_wr = xfer & ~dir_to_host;

endmodule

// File: rtl/dmareq_ctrl_chk.sv
module dmareq_ctrl_chk #(
  parameter int unsigned BURST_MAX = 32
) (
  input logic clk,
  input logic rst_n,
  input logic fifo_empty,
  input logic fifo_full,
  input logic dir_to_host,
  input logic dma_enable,
  input logic svc_intr,
  input logic dreq,
  input logic fifo_rd,
  input logic fifo_wr,
  input logic irq,
  input logic svc_set
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else if (!dreq) begin
      run_q <= 0;
    end else if (fifo_rd || fifo_wr) begin
      run_q <= run_q + 1;
    end
  end

  a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_enable || svc_intr) |=> !dreq);

  a_r2_empty_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_to_host && fifo_empty) |=> !dreq);

  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_to_host && fifo_full) |=> !dreq);

  a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    svc_set |=> irq);

  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    svc_set |=> !dreq);

  a_r4_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= BURST_MAX);

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd || fifo_wr) |=> !(fifo_rd || fifo_wr));

endmodule

bind dmareq_ctrl dmareq_ctrl_chk #(.BURST_MAX(BURST_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_empty  (fifo_empty),
  .fifo_full   (fifo_full),
  .dir_to_host (dir_to_host),
  .dma_enable  (dma_enable),
  .svc_intr    (svc_intr),
  .dreq        (dreq),
  .fifo_rd     (fifo_rd),
  .fifo_wr     (fifo_wr),
  .irq         (irq),
  .svc_set     (svc_set)
);

// File: tb/dmareq_ctrl_bench.sv
`timescale 1ns/1ps
module dmareq_ctrl_bench;

  localparam int CLK_PERIOD = 20;
  localparam int BURST      = 32;
  localparam int HOLD       = (350 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic rst_n, fifo_empty, fifo_full, dir_to_host, dma_enable, svc_intr;
  logic dack_n, ior_n, tc;
  logic dreq, fifo_rd, fifo_wr, irq, svc_set;

  int vectors = 0;
  int miscompares = 0;
  int rd_cnt, wr_cnt;
  bit saw_svc, saw_irq;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmareq_ctrl #(.BURST_MAX(BURST), .CLK_NS(CLK_PERIOD), .HOLD_NS(350)) u_dmareq_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .dir_to_host(dir_to_host), .dma_enable(dma_enable), .svc_intr(svc_intr),
    .dack_n(dack_n), .ior_n(ior_n), .tc(tc), .dreq(dreq), .fifo_rd(fifo_rd),
    .fifo_wr(fifo_wr), .irq(irq), .svc_set(svc_set)
  );

  // Behavioural reference model
  bit mr1, mr2, ma1, ma2, ma3, mi1, mi2, mi3, mreq, mirq, mhold;
  int mcnt, mtmr, mlock;

  task automatic model_clear();
    ma1 = 1; ma2 = 1; ma3 = 1; mi1 = 1; mi2 = 1; mi3 = 1;
    mreq = 0; mirq = 0; mhold = 0; mcnt = 0; mtmr = 0; mlock = 0;
  endtask

  function automatic bit model_xfer();
    return (ma3 && !ma2) || (dir_to_host && !ma2 && mi3 && !mi2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 0; mr2 = 0;
      model_clear();
    end else begin
      if (!mr2) begin
        model_clear();
      end else begin
        bit x, hit, lim, nreq, room;
        x    = model_xfer();
        hit  = x && tc;
        lim  = x && (mcnt == BURST - 1);
        room = dir_to_host ? !fifo_empty : !fifo_full;
        nreq = dma_enable && !svc_intr && (mlock == 0) && !mhold && room && !hit && !lim;
        if (mhold) begin
          mcnt = 0;
          if (!ma2) mtmr = 0;
          else if (mtmr == HOLD - 1) begin mhold = 0; mtmr = 0; end
          else mtmr = mtmr + 1;
        end else if (lim) begin
          mcnt = 0; mhold = 1; mtmr = 0;
        end else if (x) mcnt = mcnt + 1;
        else if (!mreq) mcnt = 0;
        case (mlock)
          0: if (hit) mlock = 1;
          1: if (svc_intr) mlock = 2;
          default: if (!svc_intr) mlock = 0;
        endcase
        mreq = nreq;
        mirq = hit;
        ma3 = ma2; ma2 = ma1; ma1 = dack_n;
        mi3 = mi2; mi2 = mi1; mi1 = ior_n;
      end
      mr2 = mr1; mr1 = 1;
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (cmp_en) begin
      bit x;
      x = model_xfer();
      vectors++;
      if ({dreq, fifo_rd, fifo_wr, irq, svc_set} !==
          {mreq, x && dir_to_host, x && !dir_to_host, mirq, x && tc}) begin
        miscompares++;
        $display("FAIL model R1..R11 t=%0t act dreq/rd/wr/irq/svc=%b%b%b%b%b exp=%b%b%b%b%b",
                 $time, dreq, fifo_rd, fifo_wr, irq, svc_set,
                 mreq, x && dir_to_host, x && !dir_to_host, mirq, x && tc);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk); #2;
      if (fifo_rd) rd_cnt++;
      if (fifo_wr) wr_cnt++;
      if (svc_set) saw_svc = 1;
      if (irq)     saw_irq = 1;
    end
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_counts();
    rd_cnt = 0; wr_cnt = 0; saw_svc = 0; saw_irq = 0;
  endtask

  task automatic dma_cycle(bit tcv);
    dack_n = 0; tc = tcv;
    step(3);
    dack_n = 1; tc = 0;
    step(3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fifo_empty = 1; fifo_full = 0; dir_to_host = 1; dma_enable = 0;
    svc_intr = 0; dack_n = 1; ior_n = 1; tc = 0;
    clear_counts();
    cmp_en = 1;
    step(3);
    // R11: reset state
    check("R11 dreq", dreq, 0);
    check("R11 irq", irq, 0);
    rst_n = 1; fifo_empty = 0; dma_enable = 1;
    step(1);
    check("R11 dreq held in release", dreq, 0);
    step(3);
    check("R2 request with data", dreq, 1);

    // R1 gating
    dma_enable = 0; step(1);
    check("R1 enable low", dreq, 0);
    dma_enable = 1; svc_intr = 1; step(1);
    check("R1 service bit high", dreq, 0);
    svc_intr = 0; step(1);
    check("R1 restore", dreq, 1);

    // R2 / R6 empty drop and re-arm
    fifo_empty = 1; step(1);
    check("R2 empty drop", dreq, 0);
    fifo_empty = 0; step(1);
    check("R6 re-arm on byte", dreq, 1);

    // R8 strobes
    clear_counts();
    dma_cycle(0); dma_cycle(0); dma_cycle(0);
    check("R8 read strobes", rd_cnt, 3);
    check("R8 no write strobes", wr_cnt, 0);

    // R7 terminal count lockout, R5 interrupt
    clear_counts();
    dma_cycle(1);
    check("R5 svc_set seen", saw_svc, 1);
    check("R5 irq seen", saw_irq, 1);
    check("R3 tc drop", dreq, 0);
    step(5);
    check("R7 locked without software", dreq, 0);
    svc_intr = 1; step(2);
    svc_intr = 0; step(1);
    check("R7 still low first clock", dreq, 0);
    step(1);
    check("R7 re-armed", dreq, 1);

    // R3 read strobe path with acknowledge held low
    clear_counts();
    dack_n = 0; step(4);
    ior_n = 0; step(3); ior_n = 1; step(3);
    check("R3 ior strobe counted", rd_cnt, 2);
    check("R3 request kept", dreq, 1);
    ior_n = 0; tc = 1; step(3); tc = 0;
    check("R3 ior tc drop", dreq, 0);
    check("R5 svc_set via ior", saw_svc, 1);
    ior_n = 1; dack_n = 1; step(3);
    svc_intr = 1; step(2); svc_intr = 0; step(2);
    check("R7 re-armed after ior tc", dreq, 1);

    // R4 burst limit
    fifo_empty = 1; step(2); fifo_empty = 0; step(2);
    for (int i = 0; i < BURST - 1; i++) dma_cycle(0);
    check("R4 request before limit", dreq, 1);
    dma_acq_last: begin
      dack_n = 0; step(3);
      check("R4 drop on 32nd", dreq, 0);
      dack_n = 1; step(3);
    end
    step(10);
    check("R4 hold-off active", dreq, 0);
    step(10);
    check("R4 released after hold-off", dreq, 1);

    // R4 + R5 coincidence on the 32nd cycle
    fifo_empty = 1; step(2); fifo_empty = 0; step(2);
    clear_counts();
    for (int i = 0; i < BURST - 1; i++) dma_cycle(0);
    dma_cycle(1);
    check("R5 svc_set on 32nd", saw_svc, 1);
    svc_intr = 1; step(1); svc_intr = 0; step(2);
    check("R4 hold-off outlasts service", dreq, 0);
    step(20);
    check("R4 R7 both released", dreq, 1);

    // R9 host-to-FIFO direction
    dir_to_host = 0; fifo_full = 1; step(2);
    check("R9 full blocks", dreq, 0);
    fifo_full = 0; step(1);
    check("R9 space requests", dreq, 1);
    clear_counts();
    dma_cycle(0);
    check("R9 write strobe", wr_cnt, 1);
    check("R9 no read strobe", rd_cnt, 0);
    ior_n = 0; step(3); ior_n = 1; step(3);
    check("R9 ior ignored for writes", wr_cnt, 1);

    // R10 software stop mid transfer
    svc_intr = 1; step(1); dma_enable = 0; step(1);
    check("R10 stopped", dreq, 0);
    clear_counts();
    dma_cycle(0);
    check("R10 strobe while stopped", wr_cnt, 1);
    check("R10 still stopped", dreq, 0);
    dma_enable = 1; step(1); svc_intr = 0; step(1);
    check("R10 restarted", dreq, 1);

    step(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule